// File: doc/BRIEF.md
# Transmit Tap Update Responder

This block answers coefficient update requests that a link partner sends during backplane link training. It keeps the three transmit equalizer settings of one lane: a pre-cursor ratio, a main-cursor setting and a post-cursor ratio. On every request strobe it decodes the partner's request word. It then steps, presets or re-initializes the settings, and it reports a two-bit status per tap back to the partner.

A step is taken only when the tap is inside its range and the stepped set satisfies the combined legality rules. A legal step that lands on a ratio the analog lane cannot use is kept internally, but it is not pushed to the lane. The block drives a packed transmit equalization control word and pulses an update flag in the cycle that word is refreshed. Once the partner reports that its receiver is ready, the responder clears all statuses and stops acting on requests.

Top module: `eq_tap_responder`

## Requirements
- R1: After reset the pre ratio is 3, the main setting is 32 and the post ratio is 13. All tap statuses are not updated (code 0), the update flag is low and the control word is 0x24ED2000.
- R2: The control word is 0x24200000 ORed with the refreshed pre ratio shifted left 22, the post ratio shifted left 16 and the main setting shifted left 8. The update flag is high for exactly the cycle after a strobe that refreshed the word. Without that flag the word does not change.
- R3: The request word carries three 2-bit codes: bits [5:4] for c(+1), [3:2] for c(0) and [1:0] for c(-1), with 0 hold, 1 increment, 2 decrement and 3 ignored. Statuses use the same positions on the status output, coded 0 not updated, 1 updated, 2 minimum, 3 maximum. Incrementing c(+1) lowers the post ratio, incrementing c(-1) lowers the pre ratio and incrementing c(0) raises the main setting. Bits [11:6] have no effect.
- R4: The post ratio stays in 0..16, the pre ratio in 0..8 and the main setting in 0..48. A step that would leave its range is not applied and reports maximum for an increment or minimum for a decrement.
- R5: A stepped set is accepted only if all of these hold: pre+post+main is at most 48; 4·(pre+post+main) is less than 17·(main−pre−post); pre is at most post; main is at least 26. A rejected step leaves the settings alone and reports maximum for an increment or minimum for a decrement.
- R6: An accepted step reports updated. If the new pre ratio is outside {0,1,3,5,7,9,11,12}, or the new post ratio is outside {0,1,3,5,7,9,11,13,15,16}, the value is held but the control word is not refreshed.
- R7: An increment or decrement acts only while that tap's status is not updated. When neither preset nor initialize is requested, a hold code returns that tap's status to not updated.
- R8: Preset is request bit 13 and initialize is bit 12. Either one acts only while all three statuses are not updated, and while either is requested, hold codes do not clear statuses. Preset loads pre 0, post 0, main 48 and reports maximum on every tap. Initialize loads the reset values and reports updated on every tap. If both are set, initialize wins. Either one refreshes the word.
- R9: A strobe with the partner-ready input high clears all statuses to not updated and leaves the settings and the word unchanged.
- R10: Within one strobe the taps are processed in the order c(+1), c(0), c(-1), and each step is judged on the settings left by the steps before it.
- R11: Statuses and settings change only on the clock edge where the request strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per partner request |
| req_word | input | 14 | Partner request word |
| partner_rx_ready | input | 1 | Partner reports its receiver trained |
| tap_stat_o | output | 6 | Per-tap status codes |
| pre_o | output | 4 | Held pre-cursor ratio |
| main_o | output | 6 | Held main-cursor setting |
| post_o | output | 5 | Held post-cursor ratio |
| ctrl_word_o | output | 32 | Packed transmit equalization control word |
| ctrl_upd_o | output | 1 | Pulse marking a refresh of the control word |

## Verification
The case that is hardest to reach from the ports is a legal step that lands off the allowed-value grid. In that case the held setting moves but the word and the flag stay quiet. Another hard case is a two-tap strobe, where the order of evaluation decides whether the second step is legal. Both need a particular history of settings and of status codes that were returned to not updated. Directed sequences therefore start from the reset settings: they raise c(+1) to reach post 12, then c(+1) and c(0) together. Long runs of random requests with many holds, occasional preset and initialize, and partner-ready strobes wander through the legal region and keep reaching the grid gaps and range edges.

// File: rtl/eq_resp_pkg.sv
`timescale 1ns/1ps
// Shared widths, codes and helpers for the transmit tap update responder.
// Assumes the three settings fit the field widths given here.
package eq_resp_pkg;
    localparam int PRE_W    = 4;
    localparam int POST_W   = 5;
    localparam int MAIN_W   = 6;
    localparam int NUM_TAPS = 3;
    localparam int CODE_W   = 2;
    // Processing order index of each tap
    localparam int TAP_POST = 0;
    localparam int TAP_MAIN = 1;
    localparam int TAP_PRE  = 2;

    typedef enum logic [1:0] {
        ST_NOT_UPD = 2'd0,
        ST_UPDATED = 2'd1,
        ST_MIN     = 2'd2,
        ST_MAX     = 2'd3
    } tap_stat_t;

    typedef enum logic [1:0] {
        RQ_HOLD = 2'd0,
        RQ_INC  = 2'd1,
        RQ_DEC  = 2'd2,
        RQ_RSVD = 2'd3
    } step_req_t;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MAIN_W-1:0] main;
        logic [POST_W-1:0] post;
    } tap_set_t;

    // Pre ratios the analog lane can realise
    function automatic logic pre_on_grid(input logic [PRE_W-1:0] v);
        logic ok;
        case (int'(v))
            0, 1, 3, 5, 7, 9, 11, 12: ok = 1'b1;
            default:                  ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Post ratios the analog lane can realise
    function automatic logic post_on_grid(input logic [POST_W-1:0] v);
        logic ok;
        case (int'(v))
            0, 1, 3, 5, 7, 9, 11, 13, 15, 16: ok = 1'b1;
            default:                          ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/eq_legal_chk.sv
`timescale 1ns/1ps
// Combined legality and grid check of one candidate tap set.
// Purely combinational; assumes settings are unsigned and within field width.
module eq_legal_chk
    import eq_resp_pkg::*;
#(
    parameter int SUM_LIMIT   = 48,
    parameter int MAIN_FLOOR  = 26,
    parameter int SUM_WEIGHT  = 4,
    parameter int DIFF_WEIGHT = 17
) (
    input  tap_set_t cand,
    output logic     legal,
    output logic     on_grid
);
    localparam int AW = MAIN_W + 6;

    logic signed [AW-1:0] sum_s;
    logic signed [AW-1:0] diff_s;
    logic signed [AW-1:0] lhs_s;
    logic signed [AW-1:0] rhs_s;

    // Weighted sum and margin of the candidate set
    always_comb begin
        sum_s  = AW'(cand.pre) + AW'(cand.post) + AW'(cand.main);
        diff_s = AW'(cand.main) - AW'(cand.pre) - AW'(cand.post);
        lhs_s  = sum_s * AW'(SUM_WEIGHT);
        rhs_s  = diff_s * AW'(DIFF_WEIGHT);
    end

    // All four inequalities must hold
    assign legal = (sum_s <= AW'(SUM_LIMIT))
                && (lhs_s < rhs_s)
                && (POST_W'(cand.pre) <= cand.post)
                && (cand.main >= MAIN_W'(MAIN_FLOOR));

    // Both outer ratios must sit on a realisable value
    assign on_grid = pre_on_grid(cand.pre) && post_on_grid(cand.post);
endmodule

// File: rtl/eq_tap_step.sv
`timescale 1ns/1ps
// One link of the per-strobe step chain: applies an increment or decrement
// to the tap selected by TAP, judged on the set left by earlier links.
// Assumes stat_in is this tap's status after hold and preset handling.
module eq_tap_step
    import eq_resp_pkg::*;
#(
    parameter int TAP         = TAP_POST,
    parameter int PRE_TOP     = 8,
    parameter int POST_TOP    = 16,
    parameter int MAIN_TOP    = 48,
    parameter int SUM_LIMIT   = 48,
    parameter int MAIN_FLOOR  = 26,
    parameter int SUM_WEIGHT  = 4,
    parameter int DIFF_WEIGHT = 17
) (
    input  step_req_t code,
    input  tap_stat_t stat_in,
    input  tap_set_t  cur_in,
    input  tap_set_t  wrd_in,
    input  logic      refresh_in,
    output tap_stat_t stat_out,
    output tap_set_t  cur_out,
    output tap_set_t  wrd_out,
    output logic      refresh_out
);
    localparam int FW = MAIN_W;

    logic [FW-1:0] fv_now;
    logic [FW-1:0] fv_new;
    logic          lim_inc;
    logic          lim_dec;
    logic          want_inc;
    logic          want_step;
    logic          at_limit;
    logic          cand_legal;
    logic          cand_grid;
    tap_set_t      cand;

    assign want_inc  = (code == RQ_INC);
    assign want_step = ((code == RQ_INC) || (code == RQ_DEC)) && (stat_in == ST_NOT_UPD);

    generate
        if (TAP == TAP_MAIN) begin : g_main
            assign fv_now  = FW'(cur_in.main);
            assign lim_inc = (fv_now == FW'(MAIN_TOP));
            assign lim_dec = (fv_now == '0);
            assign fv_new  = want_inc ? fv_now + FW'(1) : fv_now - FW'(1);
            // Candidate set with the main setting moved
            always_comb begin
                cand      = cur_in;
                cand.main = MAIN_W'(fv_new);
            end
        end else if (TAP == TAP_POST) begin : g_post
            assign fv_now  = FW'(cur_in.post);
            assign lim_inc = (fv_now == '0);
            assign lim_dec = (fv_now == FW'(POST_TOP));
            assign fv_new  = want_inc ? fv_now - FW'(1) : fv_now + FW'(1);
            // Candidate set with the post ratio moved (inverted sense)
            always_comb begin
                cand      = cur_in;
                cand.post = POST_W'(fv_new);
            end
        end else begin : g_pre
            assign fv_now  = FW'(cur_in.pre);
            assign lim_inc = (fv_now == '0);
            assign lim_dec = (fv_now == FW'(PRE_TOP));
            assign fv_new  = want_inc ? fv_now - FW'(1) : fv_now + FW'(1);
            // Candidate set with the pre ratio moved (inverted sense)
            always_comb begin
                cand     = cur_in;
                cand.pre = PRE_W'(fv_new);
            end
        end
    endgenerate

    assign at_limit = want_inc ? lim_inc : lim_dec;

    eq_legal_chk #(
        .SUM_LIMIT  (SUM_LIMIT),
        .MAIN_FLOOR (MAIN_FLOOR),
        .SUM_WEIGHT (SUM_WEIGHT),
        .DIFF_WEIGHT(DIFF_WEIGHT)
    ) u_legal (
        .cand   (cand),
        .legal  (cand_legal),
        .on_grid(cand_grid)
    );

    // Decide the outcome of this link
    always_comb begin
        stat_out    = stat_in;
        cur_out     = cur_in;
        wrd_out     = wrd_in;
        refresh_out = refresh_in;
        if (want_step) begin
            if (at_limit || !cand_legal) begin
                stat_out = want_inc ? ST_MAX : ST_MIN;
            end else begin
                stat_out = ST_UPDATED;
                cur_out  = cand;
                if (cand_grid) begin
                    wrd_out     = cand;
                    refresh_out = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/eq_tap_responder.sv
`timescale 1ns/1ps
// Transmit tap update responder: decodes partner requests on each strobe,
// applies hold, preset, initialize and per-tap steps, keeps the per-tap
// status and drives the packed equalization control word.
// Assumes at most one request per strobe; req_word is sampled only with req_valid.
module eq_tap_responder
    import eq_resp_pkg::*;
#(
    parameter int                WORD_W      = 32,
    parameter int                REQ_W       = 14,
    parameter logic [WORD_W-1:0] BASE_WORD   = 32'h2420_0000,
    parameter int                PRE_LSB     = 22,
    parameter int                POST_LSB    = 16,
    parameter int                MAIN_LSB    = 8,
    parameter int                PRESET_BIT  = 13,
    parameter int                INIT_BIT    = 12,
    parameter int                DEF_PRE     = 3,
    parameter int                DEF_MAIN    = 32,
    parameter int                DEF_POST    = 13,
    parameter int                PSET_PRE    = 0,
    parameter int                PSET_MAIN   = 48,
    parameter int                PSET_POST   = 0,
    parameter int                PRE_TOP     = 8,
    parameter int                POST_TOP    = 16,
    parameter int                MAIN_TOP    = 48,
    parameter int                SUM_LIMIT   = 48,
    parameter int                MAIN_FLOOR  = 26,
    parameter int                SUM_WEIGHT  = 4,
    parameter int                DIFF_WEIGHT = 17
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [REQ_W-1:0]           req_word,
    input  logic                       partner_rx_ready,
    output logic [CODE_W*NUM_TAPS-1:0] tap_stat_o,
    output logic [PRE_W-1:0]           pre_o,
    output logic [MAIN_W-1:0]          main_o,
    output logic [POST_W-1:0]          post_o,
    output logic [WORD_W-1:0]          ctrl_word_o,
    output logic                       ctrl_upd_o
);
    localparam int       CODE_BITS = CODE_W * NUM_TAPS;
    localparam tap_set_t DEFAULTS  = '{pre: PRE_W'(DEF_PRE), main: MAIN_W'(DEF_MAIN),
                                       post: POST_W'(DEF_POST)};
    localparam tap_set_t PRESETS   = '{pre: PRE_W'(PSET_PRE), main: MAIN_W'(PSET_MAIN),
                                       post: POST_W'(PSET_POST)};

    tap_stat_t st_q    [NUM_TAPS];
    tap_stat_t st_hold [NUM_TAPS];
    tap_stat_t st_ctl  [NUM_TAPS];
    tap_stat_t st_step [NUM_TAPS];
    tap_stat_t st_fin  [NUM_TAPS];
    step_req_t code    [NUM_TAPS];

    tap_set_t cur_q, wrd_q;
    tap_set_t cur_ctl, wrd_ctl;
    tap_set_t cur_ch [NUM_TAPS+1];
    tap_set_t wrd_ch [NUM_TAPS+1];
    logic     ref_ch [NUM_TAPS+1];
    tap_set_t cur_fin, wrd_fin;
    logic     ref_ctl, ref_fin;
    logic     upd_q;
    logic     preset_req, init_req, ctl_req, all_idle;
    logic     unused_req_bits;

    assign preset_req      = req_word[PRESET_BIT];
    assign init_req        = req_word[INIT_BIT];
    assign ctl_req         = preset_req || init_req;
    assign unused_req_bits = ^req_word[INIT_BIT-1:CODE_BITS];

    // Request code per tap; the c(+1) code sits in the top pair of bits
    generate
        for (genvar g = 0; g < NUM_TAPS; g++) begin : g_code
            assign code[g] = step_req_t'(req_word[CODE_W*(NUM_TAPS-1-g) +: CODE_W]);
            assign tap_stat_o[CODE_W*(NUM_TAPS-1-g) +: CODE_W] = st_q[g];
        end
    endgenerate

    // Hold codes return a tap to not updated unless preset/initialize is asked
    always_comb begin
        all_idle = 1'b1;
        for (int t = 0; t < NUM_TAPS; t++) begin
            st_hold[t] = (!ctl_req && code[t] == RQ_HOLD) ? ST_NOT_UPD : st_q[t];
            if (st_q[t] != ST_NOT_UPD) all_idle = 1'b0;
        end
    end

    // Preset and initialize, gated on every tap being not updated
    always_comb begin
        st_ctl  = st_hold;
        cur_ctl = cur_q;
        wrd_ctl = wrd_q;
        ref_ctl = 1'b0;
        if (ctl_req && all_idle) begin
            if (preset_req) begin
                cur_ctl = PRESETS;
                for (int t = 0; t < NUM_TAPS; t++) st_ctl[t] = ST_MAX;
            end
            if (init_req) begin
                cur_ctl = DEFAULTS;
                for (int t = 0; t < NUM_TAPS; t++) st_ctl[t] = ST_UPDATED;
            end
            wrd_ctl = cur_ctl;
            ref_ctl = 1'b1;
        end
    end

    assign cur_ch[0] = cur_ctl;
    assign wrd_ch[0] = wrd_ctl;
    assign ref_ch[0] = ref_ctl;

    // Step chain in processing order c(+1), c(0), c(-1)
    generate
        for (genvar g = 0; g < NUM_TAPS; g++) begin : g_chain
            eq_tap_step #(
                .TAP        (g),
                .PRE_TOP    (PRE_TOP),
                .POST_TOP   (POST_TOP),
                .MAIN_TOP   (MAIN_TOP),
                .SUM_LIMIT  (SUM_LIMIT),
                .MAIN_FLOOR (MAIN_FLOOR),
                .SUM_WEIGHT (SUM_WEIGHT),
                .DIFF_WEIGHT(DIFF_WEIGHT)
            ) u_step (
                .code       (code[g]),
                .stat_in    (st_ctl[g]),
                .cur_in     (cur_ch[g]),
                .wrd_in     (wrd_ch[g]),
                .refresh_in (ref_ch[g]),
                .stat_out   (st_step[g]),
                .cur_out    (cur_ch[g+1]),
                .wrd_out    (wrd_ch[g+1]),
                .refresh_out(ref_ch[g+1])
            );
        end
    endgenerate

    // Partner ready overrides everything: clear statuses, no processing
    always_comb begin
        if (partner_rx_ready) begin
            for (int t = 0; t < NUM_TAPS; t++) st_fin[t] = ST_NOT_UPD;
            cur_fin = cur_q;
            wrd_fin = wrd_q;
            ref_fin = 1'b0;
        end else begin
            st_fin  = st_step;
            cur_fin = cur_ch[NUM_TAPS];
            wrd_fin = wrd_ch[NUM_TAPS];
            ref_fin = ref_ch[NUM_TAPS];
        end
    end

    // State registers, loaded only on a request strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TAPS; t++) st_q[t] <= ST_NOT_UPD;
            cur_q <= DEFAULTS;
            wrd_q <= DEFAULTS;
            upd_q <= 1'b0;
        end else if (req_valid) begin
            st_q  <= st_fin;
            cur_q <= cur_fin;
            wrd_q <= wrd_fin;
            upd_q <= ref_fin;
        end else begin
            upd_q <= 1'b0;
        end
    end

    assign pre_o       = cur_q.pre;
    assign main_o      = cur_q.main;
    assign post_o      = cur_q.post;
    assign ctrl_upd_o  = upd_q;
    assign ctrl_word_o = BASE_WORD
                       | (WORD_W'(wrd_q.pre)  << PRE_LSB)
                       | (WORD_W'(wrd_q.post) << POST_LSB)
                       | (WORD_W'(wrd_q.main) << MAIN_LSB);
endmodule

// File: rtl/eq_tap_responder_chk.sv
`timescale 1ns/1ps
// Property checker for the transmit tap update responder, bound to the top.
// Observes ports only.
module eq_tap_responder_chk
    import eq_resp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PRE_TOP    = 8,
    parameter int POST_TOP   = 16,
    parameter int MAIN_TOP   = 48,
    parameter int MAIN_FLOOR = 26
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       partner_rx_ready,
    input logic [CODE_W*NUM_TAPS-1:0] tap_stat_o,
    input logic [PRE_W-1:0]           pre_o,
    input logic [MAIN_W-1:0]          main_o,
    input logic [POST_W-1:0]          post_o,
    input logic [WORD_W-1:0]          ctrl_word_o,
    input logic                       ctrl_upd_o
);
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(tap_stat_o) && $stable(pre_o) && $stable(main_o) && $stable(post_o)))
        else $error("p_quiet_idle_r11");

    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_upd_o |-> $past(req_valid))
        else $error("p_pulse_cause_r2");

    p_word_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_upd_o |-> $stable(ctrl_word_o))
        else $error("p_word_quiet_r2");

    p_ready_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && partner_rx_ready) |=> (tap_stat_o == '0 && !ctrl_upd_o))
        else $error("p_ready_clear_r9");

    p_ready_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && partner_rx_ready) |=> ($stable(pre_o) && $stable(main_o) && $stable(post_o)))
        else $error("p_ready_freeze_r9");

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pre_o) <= PRE_TOP) && (32'(post_o) <= POST_TOP) && (32'(main_o) <= MAIN_TOP))
        else $error("p_range_r4");

    p_legal_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (POST_W'(pre_o) <= post_o) && (32'(main_o) >= MAIN_FLOOR))
        else $error("p_legal_set_r5");
endmodule

bind eq_tap_responder eq_tap_responder_chk #(
    .WORD_W    (WORD_W),
    .PRE_TOP   (PRE_TOP),
    .POST_TOP  (POST_TOP),
    .MAIN_TOP  (MAIN_TOP),
    .MAIN_FLOOR(MAIN_FLOOR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .partner_rx_ready(partner_rx_ready),
    .tap_stat_o      (tap_stat_o),
    .pre_o           (pre_o),
    .main_o          (main_o),
    .post_o          (post_o),
    .ctrl_word_o     (ctrl_word_o),
    .ctrl_upd_o      (ctrl_upd_o)
);

// File: tb/sim_eq_tap_responder.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases then seeded random requests,
// compared with a requirement-level model of the responder.
module sim_eq_tap_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_word = '0;
    logic        partner_rx_ready = 1'b0;
    logic [5:0]  tap_stat_o;
    logic [3:0]  pre_o;
    logic [5:0]  main_o;
    logic [4:0]  post_o;
    logic [31:0] ctrl_word_o;
    logic        ctrl_upd_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state, index 0 = post/c(+1), 1 = main/c(0), 2 = pre/c(-1)
    int mv [3];
    int mw [3];
    int ms [3];
    bit mp;

    always #5 clk = ~clk;

    eq_tap_responder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .partner_rx_ready(partner_rx_ready), .tap_stat_o(tap_stat_o),
        .pre_o(pre_o), .main_o(main_o), .post_o(post_o),
        .ctrl_word_o(ctrl_word_o), .ctrl_upd_o(ctrl_upd_o)
    );

    function automatic bit legal_set(int po, int ma, int pr);
        int s;
        s = po + ma + pr;
        return (s <= 48) && (4 * s < 17 * (ma - pr - po)) && (pr <= po) && (ma >= 26);
    endfunction

    function automatic bit on_grid(int po, int pr);
        bit a, b;
        a = (pr inside {0, 1, 3, 5, 7, 9, 11, 12});
        b = (po inside {0, 1, 3, 5, 7, 9, 11, 13, 15, 16});
        return a && b;
    endfunction

    function automatic logic [31:0] exp_word();
        return 32'h2420_0000 | (32'(mw[2]) << 22) | (32'(mw[0]) << 16) | (32'(mw[1]) << 8);
    endfunction

    task automatic model_apply(input logic [13:0] rq, input bit rx);
        int  code [3];
        bit  ctl, idle, inc, lim;
        int  c [3];
        ctl  = rq[13] | rq[12];
        idle = (ms[0] == 0) && (ms[1] == 0) && (ms[2] == 0);
        mp   = 1'b0;
        for (int t = 0; t < 3; t++) code[t] = int'((rq >> (2 * (2 - t))) & 14'h3);
        if (!ctl) for (int t = 0; t < 3; t++) if (code[t] == 0) ms[t] = 0;
        if (rx) begin
            for (int t = 0; t < 3; t++) ms[t] = 0;
        end else begin
            if (ctl && idle) begin
                if (rq[13]) begin mv = '{0, 48, 0};  for (int t = 0; t < 3; t++) ms[t] = 3; end
                if (rq[12]) begin mv = '{13, 32, 3}; for (int t = 0; t < 3; t++) ms[t] = 1; end
                mw = mv;
                mp = 1'b1;
            end
            for (int t = 0; t < 3; t++) begin
                if ((code[t] == 1 || code[t] == 2) && ms[t] == 0) begin
                    inc = (code[t] == 1);
                    if (t == 1) lim = inc ? (mv[1] == 48) : (mv[1] == 0);
                    else if (t == 0) lim = inc ? (mv[0] == 0) : (mv[0] == 16);
                    else lim = inc ? (mv[2] == 0) : (mv[2] == 8);
                    c = mv;
                    if (lim) ms[t] = inc ? 3 : 2;
                    else begin
                        if (t == 1) c[t] = c[t] + (inc ? 1 : -1);
                        else        c[t] = c[t] + (inc ? -1 : 1);
                        if (!legal_set(c[0], c[1], c[2])) ms[t] = inc ? 3 : 2;
                        else begin
                            mv    = c;
                            ms[t] = 1;
                            if (on_grid(c[0], c[2])) begin mw = c; mp = 1'b1; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [5:0]  es;
        logic [14:0] et, at;
        es = {2'(ms[0]), 2'(ms[1]), 2'(ms[2])};
        et = {4'(mv[2]), 6'(mv[1]), 5'(mv[0])};
        at = {pre_o, main_o, post_o};
        chk(tap_stat_o === es, tag, "status", 32'(tap_stat_o), 32'(es));
        chk(at === et, tag, "taps", 32'(at), 32'(et));
        chk(ctrl_word_o === exp_word(), tag, "word", ctrl_word_o, exp_word());
        chk(ctrl_upd_o === mp, tag, "upd", 32'(ctrl_upd_o), 32'(mp));
    endtask

    task automatic strobe(input logic [13:0] rq, input bit rx, input string tag);
        @(negedge clk);
        req_word = rq;
        partner_rx_ready = rx;
        req_valid = 1'b1;
        model_apply(rq, rx);
        @(negedge clk);
        req_valid = 1'b0;
        partner_rx_ready = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle_cycles(input int n);
        mp = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_word = 14'($urandom);
            partner_rx_ready = 1'($urandom);
            compare_all("R11 idle");
        end
        partner_rx_ready = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [13:0] rq;
        int r;
        void'($urandom(32'd20240611));
        mv = '{13, 32, 3};
        mw = '{13, 32, 3};
        ms = '{0, 0, 0};
        mp = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values against literal constants
        chk(tap_stat_o === 6'h00, "R1", "status", 32'(tap_stat_o), 32'h0);
        chk({pre_o, main_o, post_o} === {4'd3, 6'd32, 5'd13}, "R1", "taps",
            32'({pre_o, main_o, post_o}), 32'({4'd3, 6'd32, 5'd13}));
        chk(ctrl_word_o === 32'h24ED2000, "R1", "word", ctrl_word_o, 32'h24ED2000);
        chk(ctrl_upd_o === 1'b0, "R1", "upd", 32'(ctrl_upd_o), 32'h0);

        strobe(14'h0010, 1'b0, "R3 R6 post inc to off-grid 12");
        chk(post_o === 5'd12 && ctrl_word_o === 32'h24ED2000, "R6", "held post",
            32'(post_o), 32'd12);
        strobe(14'h0010, 1'b0, "R7 step ignored while updated");
        strobe(14'h0000, 1'b0, "R7 hold clears");
        strobe(14'h0010, 1'b0, "R2 post inc to 11 refreshes");
        chk(ctrl_word_o === 32'h24EB2000, "R2", "word", ctrl_word_o, 32'h24EB2000);
        strobe(14'h2000, 1'b0, "R8 preset gated by status");
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h2000, 1'b0, "R8 preset");
        chk(ctrl_word_o === 32'h24203000 && tap_stat_o === 6'h3F, "R8", "preset word",
            ctrl_word_o, 32'h24203000);
        strobe(14'h2000, 1'b0, "R8 preset keeps status");
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h0004, 1'b0, "R4 main inc at top");
        chk(tap_stat_o === 6'h0C, "R4", "max status", 32'(tap_stat_o), 32'h0C);
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h0008, 1'b0, "R3 main dec");
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h0002, 1'b0, "R5 pre above post rejected");
        chk(tap_stat_o === 6'h02 && pre_o === 4'd0, "R5", "min status", 32'(tap_stat_o), 32'h02);
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h0010, 1'b0, "R4 post inc at zero");
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h1000, 1'b0, "R8 initialize");
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h3000, 1'b0, "R8 both, initialize wins");
        chk(tap_stat_o === 6'h15, "R8", "init status", 32'(tap_stat_o), 32'h15);
        strobe(14'h0000, 1'b0, "R7 hold");
        strobe(14'h0014, 1'b0, "R10 post then main");
        chk(main_o === 6'd33 && post_o === 5'd12, "R10", "main", 32'(main_o), 32'd33);
        strobe(14'h0FD5, 1'b1, "R9 partner ready clears");
        strobe(14'h0FC0, 1'b0, "R3 noise bits ignored");
        idle_cycles(6);

        for (int it = 0; it < 3000; it++) begin
            rq = '0;
            for (int t = 0; t < 3; t++) begin
                r = int'($urandom % 8);
                rq[2*(2-t) +: 2] = (r < 4) ? 2'd0 : (r < 6) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
            end
            rq[11:6] = 6'($urandom);
            r = int'($urandom % 24);
            rq[13] = (r == 0);
            rq[12] = (r == 1) || (r == 2 && ($urandom % 2 == 0));
            strobe(rq, ($urandom % 40) == 0, "R3 R4 R5 R6 R10 random");
            if (it % 100 == 99) idle_cycles(2);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule